// File: doc/BRIEF.md
# Per-Master Parity Error Capture Unit

This unit keeps a record of the first parity error seen for each of four local-bus masters on the PCI side. Each master has its own error address register and its own byte in a shared syndrome register. When a parity error is reported, the unit uses the two-bit master ID to pick the entry. It can store the transaction address, the error-type code and the read/write direction in that entry. The address and the syndrome byte are each protected by their own lock.

Each lock is a small two-state machine. An address lock is either `ADDR_OPEN` or `ADDR_HELD`. A field lock is either `FLD_OPEN` or `FLD_HELD`. An open lock moves to its held state on a capture, along the transition named *capture*. A held lock returns to its open state when software writes 1 to its bit, along the transition named *release*. An open lock ignores a release, and a held lock ignores a capture. A capture happens only when both the parity-error-response enable and the local-bus error enable are set.

Software reads and writes the entries through a simple register port.
- Selects 0 to 3 read the address registers. These registers are read-only.
- Select 4 is the syndrome register. The byte for master m sits at bits [8m+7:8m]:
  - bits [2:0] hold the error type
  - bit 3 holds the read/write status
  - bit 4 is the field lock
  - bit 5 is the address lock
  - bits 6 and 7 read as 0
- Any other select reads as 0.

Top module: `perr_capture_unit`

## Requirements
- R1: After reset, all four address registers and the syndrome register read 0.
- R2: An error strobe, with both enables set and the selected master's address lock open, loads the address into the register for that master ID (selects 0 to 3). It also sets that master's address lock, bit 5 of its syndrome byte.
- R3: While a master's address lock is held, later errors from that master leave its address register unchanged.
- R4: A capture with the master's field lock open writes the following into that master's syndrome byte:
  - error type 3'b001 in bits [2:0]
  - read/write status in bit 3, 1 for a read and 0 for a write
  - field lock set in bit 4

  While the field lock is held, the byte's type and status bits do not change.
- R5: An error strobe with either enable clear changes no register.
- R6: Writing 1 to a master's field-lock bit in the syndrome register (select 4) clears that lock, the error type and the status. Writing 0 has no effect.
- R7: Writing 1 to a master's address-lock bit clears that lock and keeps the stored address. The next error from that master is captured again, while a held field lock still blocks the field update.
- R8: Entries of different masters update independently in the same cycle, including a capture for one master during a software release for another.
- R9: When a capture and a software release target the same open lock in the same cycle, the capture wins and the lock ends up held.
- R10: Writes to the address registers (selects 0 to 3) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_strobe | input | 1 | One-cycle parity error report |
| err_master | input | 2 | ID of the master of the failing transaction |
| err_addr | input | 32 | Address of the failing transaction |
| err_is_read | input | 1 | 1 for a read, 0 for a write |
| perr_resp_en | input | 1 | Parity-error-response enable |
| bus_err_en | input | 1 | Local-bus error enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 to 3 address, 4 syndrome |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions take the inputs to be known after reset.

The assertion for R5 (disabled enables change nothing) leaves out cycles that also carry a syndrome write. A software release in such a cycle would legitimately change the syndrome register.

The stimulus drives each input only at the falling clock edge and holds every strobe for exactly one cycle. The only cycles with a register write at the same time as an error are the R8 and R9 collision cases.

// File: rtl/perr_capture_pkg.sv
package perr_capture_pkg;
    localparam int unsigned NUM_MASTERS = 4;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned FIELD_W     = 8;
    localparam int unsigned ID_W        = $clog2(NUM_MASTERS);
    localparam int unsigned SEL_W       = $clog2(NUM_MASTERS + 1);

    localparam logic [2:0] ETYPE_NONE   = 3'b000;
    localparam logic [2:0] ETYPE_PARITY = 3'b001;

    localparam int unsigned BIT_RWS     = 3;
    localparam int unsigned BIT_FLOCK   = 4;
    localparam int unsigned BIT_ALOCK   = 5;

    typedef enum logic {ADDR_OPEN, ADDR_HELD} addr_state_e;
    typedef enum logic {FLD_OPEN, FLD_HELD}   fld_state_e;
endpackage

// File: rtl/perr_addr_slot.sv
module perr_addr_slot
    import perr_capture_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_req,
    input  logic              rel_req,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              held
);
    addr_state_e state_q, state_d;
    logic        load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ADDR_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ADDR_OPEN: if (cap_req) begin
                state_d = ADDR_HELD;
                load    = 1'b1;
            end
            ADDR_HELD: if (rel_req) state_d = ADDR_OPEN;
            default:   state_d = ADDR_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= cap_addr;
    end

    assign held = (state_q == ADDR_HELD);

    a_r2_capture_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_req && !held) |=> (held && addr_q == $past(cap_addr)));
    a_r3_held_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(addr_q));
endmodule

// File: rtl/perr_synd_field.sv
module perr_synd_field
    import perr_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_req,
    input  logic       cap_read,
    input  logic       rel_req,
    output logic [2:0] etype_q,
    output logic       rws_q,
    output logic       held
);
    fld_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLD_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLD_OPEN: if (cap_req) state_d = FLD_HELD;
            FLD_HELD: if (rel_req) state_d = FLD_OPEN;
            default:  state_d = FLD_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            etype_q <= ETYPE_NONE;
            rws_q   <= 1'b0;
        end else if (state_q == FLD_OPEN && cap_req) begin
            etype_q <= ETYPE_PARITY;
            rws_q   <= cap_read;
        end else if (state_q == FLD_HELD && rel_req) begin
            etype_q <= ETYPE_NONE;
            rws_q   <= 1'b0;
        end
    end

    assign held = (state_q == FLD_HELD);

    a_r4_held_is_parity: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (etype_q == ETYPE_PARITY));
    a_r4_held_field_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rel_req) |=> ($stable(etype_q) && $stable(rws_q) && held));
    a_r6_open_field_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !held |-> (etype_q == ETYPE_NONE && !rws_q));
endmodule

// File: rtl/perr_capture_unit.sv
module perr_capture_unit
    import perr_capture_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_strobe,
    input  logic [ID_W-1:0]   err_master,
    input  logic [DATA_W-1:0] err_addr,
    input  logic              err_is_read,
    input  logic              perr_resp_en,
    input  logic              bus_err_en,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [SEL_W-1:0] SEL_SYND = SEL_W'(NUM_MASTERS);

    logic                 cap_ok;
    logic                 synd_wr;
    logic [DATA_W-1:0]    addr_regs [NUM_MASTERS];
    logic [DATA_W-1:0]    synd_vec;

    assign cap_ok  = err_strobe && perr_resp_en && bus_err_en;
    assign synd_wr = reg_wr && (reg_sel == SEL_SYND);

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
        logic       hit;
        logic       a_held, f_held, rws;
        logic [2:0] etype;

        assign hit = cap_ok && (err_master == ID_W'(m));

        perr_addr_slot #(.ADDR_W(DATA_W)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_req  (hit),
            .rel_req  (synd_wr && reg_wdata[m*FIELD_W + BIT_ALOCK]),
            .cap_addr (err_addr),
            .addr_q   (addr_regs[m]),
            .held     (a_held)
        );

        perr_synd_field u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_req  (hit),
            .cap_read (err_is_read),
            .rel_req  (synd_wr && reg_wdata[m*FIELD_W + BIT_FLOCK]),
            .etype_q  (etype),
            .rws_q    (rws),
            .held     (f_held)
        );

        assign synd_vec[m*FIELD_W +: FIELD_W] = {2'b00, a_held, f_held, rws, etype};
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_SYND) reg_rdata = synd_vec;
        else if (reg_sel < SEL_SYND) reg_rdata = addr_regs[reg_sel[ID_W-1:0]];
    end

    a_r5_disabled_no_synd_change: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !(perr_resp_en && bus_err_en) && !synd_wr) |=> $stable(synd_vec));
    a_r5_disabled_no_addr_change: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !(perr_resp_en && bus_err_en)) |=> $stable(addr_regs[0]));
endmodule

// File: tb/perr_capture_unit_tb_top.sv
module perr_capture_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        err_strobe, err_is_read, perr_resp_en, bus_err_en, reg_wr;
    logic [1:0]  err_master;
    logic [31:0] err_addr, reg_wdata, reg_rdata;
    logic [2:0]  reg_sel;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_synd;
    logic [31:0] exp_addr [4];

    always #4 clk = ~clk;

    perr_capture_unit dut_i (
        .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_master(err_master),
        .err_addr(err_addr), .err_is_read(err_is_read), .perr_resp_en(perr_resp_en),
        .bus_err_en(bus_err_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check_reg(input logic [2:0] sel, input logic [31:0] exp, input string req);
        reg_sel = sel;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, reg_rdata, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 4; i++) check_reg(3'(i), exp_addr[i], req);
        check_reg(3'd4, exp_synd, req);
    endtask

    // one clock with optional error and optional register write
    task automatic step(input logic err, input logic [1:0] id, input logic [31:0] a,
                        input logic rd, input logic pe, input logic be,
                        input logic wr, input logic [2:0] sel, input logic [31:0] wd);
        @(negedge clk);
        err_strobe = err; err_master = id; err_addr = a; err_is_read = rd;
        perr_resp_en = pe; bus_err_en = be;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(negedge clk);
        err_strobe = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        check_all("R1");
    endtask

    task automatic t_enables;
        step(1, 2'd0, 32'hDEAD_0001, 1, 0, 1, 0, 3'd0, 0);
        step(1, 2'd0, 32'hDEAD_0002, 1, 1, 0, 0, 3'd0, 0);
        step(1, 2'd0, 32'hDEAD_0003, 0, 0, 0, 0, 3'd0, 0);
        check_all("R5");
    endtask

    task automatic t_capture_basic;
        step(1, 2'd1, 32'hA000_0010, 1, 1, 1, 0, 3'd0, 0);
        exp_addr[1] = 32'hA000_0010;
        exp_synd[15:8] = 8'h39;
        check_all("R2 R4");
    endtask

    task automatic t_lock_hold;
        step(1, 2'd1, 32'hB000_0020, 0, 1, 1, 0, 3'd0, 0);
        check_all("R3 R4");
    endtask

    task automatic t_master_write;
        step(1, 2'd3, 32'hC000_0030, 0, 1, 1, 0, 3'd0, 0);
        exp_addr[3] = 32'hC000_0030;
        exp_synd[31:24] = 8'h31;
        check_all("R4");
    endtask

    task automatic t_field_release;
        step(0, 2'd0, 0, 0, 1, 1, 1, 3'd4, 32'h0000_0000);
        check_all("R6");
        step(0, 2'd0, 0, 0, 1, 1, 1, 3'd4, 32'h0000_1000);
        exp_synd[15:8] = 8'h20;
        check_all("R6");
        step(1, 2'd1, 32'hD000_0040, 0, 1, 1, 0, 3'd0, 0);
        exp_synd[15:8] = 8'h31;
        check_all("R6 R3");
    endtask

    task automatic t_addr_release;
        step(0, 2'd0, 0, 0, 1, 1, 1, 3'd4, 32'h0000_2000);
        exp_synd[15:8] = 8'h11;
        check_all("R7");
        step(1, 2'd1, 32'hE000_0050, 1, 1, 1, 0, 3'd0, 0);
        exp_addr[1] = 32'hE000_0050;
        exp_synd[15:8] = 8'h31;
        check_all("R7");
    endtask

    task automatic t_read_only;
        step(0, 2'd0, 0, 0, 1, 1, 1, 3'd0, 32'h1234_5678);
        step(0, 2'd0, 0, 0, 1, 1, 1, 3'd3, 32'h0BAD_0BAD);
        check_all("R10");
    endtask

    task automatic t_parallel;
        step(1, 2'd0, 32'hF000_0060, 1, 1, 1, 1, 3'd4, 32'h3000_0000);
        exp_addr[0] = 32'hF000_0060;
        exp_synd[7:0]   = 8'h39;
        exp_synd[31:24] = 8'h00;
        check_all("R8");
    endtask

    task automatic t_collide;
        step(1, 2'd2, 32'h1700_0070, 0, 1, 1, 1, 3'd4, 32'h0030_0000);
        exp_addr[2] = 32'h1700_0070;
        exp_synd[23:16] = 8'h31;
        check_all("R9");
    endtask

    initial begin
        rst_n = 1'b0; err_strobe = 0; err_master = 0; err_addr = 0; err_is_read = 0;
        perr_resp_en = 0; bus_err_en = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        exp_synd = 0;
        for (int i = 0; i < 4; i++) exp_addr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_enables;
        t_capture_basic;
        t_lock_hold;
        t_master_write;
        t_field_release;
        t_addr_release;
        t_read_only;
        t_parallel;
        t_collide;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule